// File: doc/BRIEF.md
# CAN Bus Wire-Failure Classifier

This block watches a two-wire, fault-tolerant low-speed CAN bus from the digital side and works out which wire has failed and how. Its inputs are the local transmit level, one pulse per dominant-to-recessive transition seen on each bus wire, and five comparator flags: overvoltage on each wire, a strongly negative differential voltage, a low level on the low wire, and a high level on the high wire. A one-cycle `us_tick` pulse once per microsecond supplies the time base for every qualify window.

Open or broken wires show up as transitions present on one wire and missing on the other. They are found by comparing transition counts between the wires. Shorts are found by requiring a comparator flag, or a pair of flags, to hold without a break for a fault-specific time. A watchdog on the transmit input removes transmit permission when the local controller holds the bus dominant for too long. The ten physical fault types that can occur collapse onto eight flags, because transition counting cannot tell an interrupted wire from one stuck at a rail. The live flags steer the receiver to single-wire operation on the healthy wire. A sticky copy of the flags is kept for status reads and is cleared bit by bit through a mask.

All pins are plain control and status levels. No data stream crosses the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `bus_fault_classifier`

## Requirements
- R1: After reset, `fault_live` and `fault_sticky` are all zero, `wire_sel` is 3'b001 (differential) and `tx_en` is 1.
- R2: Each wire keeps a transition count. Counts are normalised so that at least one of them is zero, and they saturate at 7. When the low-wire count exceeds 3, bit 0 (high wire missing transitions) rises at the following clock edge. When the high-wire count exceeds 3, bit 1 (low wire missing transitions) rises at the following clock edge. An excess of exactly 3 sets nothing.
- R3: A set count-difference flag clears at the clock edge that captures the third transition seen on the affected wire after the flag rose. Both counts then restart from zero.
- R4: Bit 2 (high wire shorted to battery) follows `h_ovv` and bit 3 (low wire shorted to battery) follows `l_ovv`, each after BATT_US ticks of the flag held continuously. The fault bit rises at the first edge at which the flag has been sampled high while BATT_US ticks were counted.
- R5: Bit 4 (low wire shorted to ground) needs `l_low` and `neg_diff` both high for SHORT_US ticks.
- R6: Bit 5 (wires shorted together) needs `neg_diff` high with `l_low` low for SHORT_US ticks.
- R7: Bit 6 (high wire shorted to the logic supply) needs `h_high` high for HVDD_US ticks.
- R8: Any cycle in which a qualify condition is low clears that fault's live bit at the next edge and restarts its tick count from zero.
- R9: Bit 7 (transmitter stuck dominant) needs `txd_dom` high for TXDOM_US ticks. While bit 7 is set, `tx_en` is 0. One edge after `txd_dom` is sampled low, `tx_en` is 1 again.
- R10: `wire_sel` is one-hot. It is 3'b100 (low wire only) when any of bits 0, 2 or 6 is live, otherwise 3'b010 (high wire only) when any of bits 1, 3, 4 or 5 is live, and otherwise 3'b001.
- R11: Each bit of `fault_sticky` sets at the edge after the matching live bit is seen high. It clears at an edge where `clr_stb` is high and the matching `clr_mask` bit is 1. A live bit that is still high wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| txd_dom | input | 1 | Local transmitter drives dominant |
| h_edge | input | 1 | Dominant-to-recessive transition on high wire |
| l_edge | input | 1 | Dominant-to-recessive transition on low wire |
| h_ovv | input | 1 | High wire above overvoltage threshold |
| l_ovv | input | 1 | Low wire above overvoltage threshold |
| neg_diff | input | 1 | Differential voltage strongly negative |
| l_low | input | 1 | Low wire below its low threshold |
| h_high | input | 1 | High wire above its high threshold |
| clr_stb | input | 1 | Apply clear mask to sticky flags |
| clr_mask | input | 8 | Sticky bits to clear |
| fault_live | output | 8 | Currently qualified faults |
| fault_sticky | output | 8 | Latched faults for status reads |
| wire_sel | output | 3 | One-hot receive mode select |
| tx_en | output | 1 | Transmit permission |

## Verification
Every cycle, the assertions check the following. At least one transition count is zero. The two count-difference flags never rise together. A flag clears only with both counts reset. No timed fault rises unless its condition was high one cycle earlier, and a dropped condition clears the live bit and the timer. `wire_sel` stays one-hot. The sticky register covers every live bit of the previous cycle. Transmit permission returns after a recessive sample. Only the bench's scenarios can show the rest. These are the exact qualify length of each window, the point where a difference of 3 still sets nothing, the third-transition recovery, the restart of counting after recovery, the priority between wires, and that a clear loses to a fault that is still live. A cycle model driven by seeded random stimulus compares every output on every cycle.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int NFLT = 8;

  // fault bit positions (outputs and clear mask share them)
  localparam int F_H_OPEN  = 0;
  localparam int F_L_OPEN  = 1;
  localparam int F_H_BATT  = 2;
  localparam int F_L_BATT  = 3;
  localparam int F_L_GND   = 4;
  localparam int F_L2H     = 5;
  localparam int F_H_VDD   = 6;
  localparam int F_TX_STUCK = 7;

  localparam int NTIMED = 6;   // faults qualified by a hold time
  localparam int TIMED_BASE = 2;

  typedef logic [2:0] wsel_t;
  localparam wsel_t SEL_DIFF  = 3'b001;
  localparam wsel_t SEL_HONLY = 3'b010;
  localparam wsel_t SEL_LONLY = 3'b100;
endpackage

// File: rtl/bfc_qual.sv
module bfc_qual #(
  parameter int LIMIT_US = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cond,
  output logic met
);
  localparam int CW = $clog2(LIMIT_US + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT_US);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      met   <= 1'b0;
    end else if (!cond) begin
      cnt_q <= '0;
      met   <= 1'b0;
    end else begin
      met <= (cnt_q == LIM);
      if (tick && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: a low condition restarts the window and drops the fault
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> (cnt_q == '0 && !met));

  // R4: a qualified fault always had its condition present the cycle before
  a_r4_cond_seen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(met) |-> $past(cond));
endmodule

// File: rtl/bfc_edge_cmp.sv
module bfc_edge_cmp #(
  parameter int DIFF_TH   = 3,
  parameter int REC_EDGES = 3,
  parameter int CNT_MAX   = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       h_edge,
  input  logic       l_edge,
  output logic [1:0] open_flag   // [0] high wire missing, [1] low wire missing
);
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int RW = $clog2(REC_EDGES + 1);
  localparam logic [CW:0]   SATV = (CW+1)'(CNT_MAX);
  localparam logic [CW-1:0] THV  = CW'(DIFF_TH);

  logic [1:0]    e;
  logic [CW-1:0] cnt_q [2];
  logic [1:0]    recov;
  logic          clr_all;
  logic [CW:0]   s0, s1, n0, n1;

  assign e = {l_edge, h_edge};
  assign clr_all = |recov;

  always_comb begin
    s0 = {1'b0, cnt_q[0]} + (CW+1)'(e[0]);
    s1 = {1'b0, cnt_q[1]} + (CW+1)'(e[1]);
    if (s0 != '0 && s1 != '0) begin
      s0 = s0 - 1'b1;
      s1 = s1 - 1'b1;
    end
    n0 = (s0 > SATV) ? SATV : s0;
    n1 = (s1 > SATV) ? SATV : s1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q[0] <= '0;
      cnt_q[1] <= '0;
    end else if (clr_all) begin
      cnt_q[0] <= '0;
      cnt_q[1] <= '0;
    end else begin
      cnt_q[0] <= n0[CW-1:0];
      cnt_q[1] <= n1[CW-1:0];
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic          op_q;
    logic [RW-1:0] rc_q;

    assign recov[s]     = op_q && e[s] && (rc_q == RW'(REC_EDGES - 1));
    assign open_flag[s] = op_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        op_q <= 1'b0;
        rc_q <= '0;
      end else begin
        if (recov[s])                op_q <= 1'b0;
        else if (cnt_q[1-s] > THV)   op_q <= 1'b1;
        if (!op_q || recov[s])       rc_q <= '0;
        else if (e[s])               rc_q <= rc_q + 1'b1;
      end
    end
  end

  // R2: normalisation keeps one counter at zero
  a_r2_one_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[0] == '0) || (cnt_q[1] == '0));

  // R2: the two count-difference faults are exclusive
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_flag[0] && open_flag[1]));

  // R3: a recovery leaves both counters at zero
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(open_flag[0]) || $fell(open_flag[1])) |-> (cnt_q[0] == '0 && cnt_q[1] == '0));
endmodule

// File: rtl/bfc_mode_sel.sv
module bfc_mode_sel
  import bfc_pkg::*;
(
  input  logic [NFLT-1:0] live,
  output wsel_t           sel
);
  logic h_bad, l_bad;

  assign h_bad = live[F_H_OPEN] | live[F_H_BATT] | live[F_H_VDD];
  assign l_bad = live[F_L_OPEN] | live[F_L_BATT] | live[F_L_GND] | live[F_L2H];

  always_comb begin
    if (h_bad)      sel = SEL_LONLY;
    else if (l_bad) sel = SEL_HONLY;
    else            sel = SEL_DIFF;
  end
endmodule

// File: rtl/bus_fault_classifier.sv
module bus_fault_classifier
  import bfc_pkg::*;
#(
  parameter int BATT_US   = 32,
  parameter int SHORT_US  = 1300,
  parameter int HVDD_US   = 1800,
  parameter int TXDOM_US  = 1300,
  parameter int DIFF_TH   = 3,
  parameter int REC_EDGES = 3,
  parameter int CNT_MAX   = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic        txd_dom,
  input  logic        h_edge,
  input  logic        l_edge,
  input  logic        h_ovv,
  input  logic        l_ovv,
  input  logic        neg_diff,
  input  logic        l_low,
  input  logic        h_high,
  input  logic        clr_stb,
  input  logic [7:0]  clr_mask,
  output logic [7:0]  fault_live,
  output logic [7:0]  fault_sticky,
  output logic [2:0]  wire_sel,
  output logic        tx_en
);
  logic [NTIMED-1:0] tcond;
  logic [NTIMED-1:0] tmet;
  logic [1:0]        open_flag;
  wsel_t             sel_w;

  assign tcond[F_H_BATT - TIMED_BASE]   = h_ovv;
  assign tcond[F_L_BATT - TIMED_BASE]   = l_ovv;
  assign tcond[F_L_GND - TIMED_BASE]    = l_low & neg_diff;
  assign tcond[F_L2H - TIMED_BASE]      = neg_diff & ~l_low;
  assign tcond[F_H_VDD - TIMED_BASE]    = h_high;
  assign tcond[F_TX_STUCK - TIMED_BASE] = txd_dom;

  for (genvar g = 0; g < NTIMED; g++) begin : g_qual
    localparam int LIM = (g + TIMED_BASE == F_H_BATT || g + TIMED_BASE == F_L_BATT) ? BATT_US :
                         (g + TIMED_BASE == F_H_VDD)    ? HVDD_US  :
                         (g + TIMED_BASE == F_TX_STUCK) ? TXDOM_US : SHORT_US;
    bfc_qual #(.LIMIT_US(LIM)) u_q (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (us_tick),
      .cond (tcond[g]),
      .met  (tmet[g])
    );
  end

  bfc_edge_cmp #(
    .DIFF_TH  (DIFF_TH),
    .REC_EDGES(REC_EDGES),
    .CNT_MAX  (CNT_MAX)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_edge   (h_edge),
    .l_edge   (l_edge),
    .open_flag(open_flag)
  );

  assign fault_live = {tmet, open_flag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_sticky <= '0;
    else        fault_sticky <= (fault_sticky & ~(clr_stb ? clr_mask : 8'h00)) | fault_live;
  end

  bfc_mode_sel u_sel (
    .live(fault_live),
    .sel (sel_w)
  );

  assign wire_sel = sel_w;
  assign tx_en    = ~fault_live[F_TX_STUCK];

  // R10: exactly one receive mode at a time
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wire_sel) == 1);

  // R11: nothing live in one cycle is missing from the sticky copy the next
  a_r11_sticky_cover: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(fault_live) & ~fault_sticky) == 8'h00));

  // R9: transmit permission comes back after a recessive sample
  a_r9_reenable: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_dom |=> tx_en);
endmodule

// File: tb/sim_bus_fault_classifier.sv
module sim_bus_fault_classifier;
  localparam int T_BATT = 4;
  localparam int T_SHORT = 20;
  localparam int T_HVDD = 25;
  localparam int T_TX = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0, txd_dom = 1'b0, h_edge = 1'b0, l_edge = 1'b0;
  logic h_ovv = 1'b0, l_ovv = 1'b0, neg_diff = 1'b0, l_low = 1'b0, h_high = 1'b0;
  logic clr_stb = 1'b0;
  logic [7:0] clr_mask = 8'h00;
  logic [7:0] fault_live, fault_sticky;
  logic [2:0] wire_sel;
  logic tx_en;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  bus_fault_classifier #(
    .BATT_US(T_BATT), .SHORT_US(T_SHORT), .HVDD_US(T_HVDD), .TXDOM_US(T_TX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .txd_dom(txd_dom),
    .h_edge(h_edge), .l_edge(l_edge), .h_ovv(h_ovv), .l_ovv(l_ovv),
    .neg_diff(neg_diff), .l_low(l_low), .h_high(h_high),
    .clr_stb(clr_stb), .clr_mask(clr_mask),
    .fault_live(fault_live), .fault_sticky(fault_sticky),
    .wire_sel(wire_sel), .tx_en(tx_en)
  );

  // ---------------- reference model built from the requirements ----------
  logic [7:0] m_live, m_stk;
  int m_ch, m_cl, m_rh, m_rl;
  int m_t [8];

  function automatic int lim(int i);
    if (i == 2 || i == 3) return T_BATT;
    if (i == 6) return T_HVDD;
    if (i == 7) return T_TX;
    return T_SHORT;
  endfunction

  function automatic logic [2:0] exp_sel(logic [7:0] lv);
    if (lv[0] || lv[2] || lv[6]) return 3'b100;
    if (lv[1] || lv[3] || lv[4] || lv[5]) return 3'b010;
    return 3'b001;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live = '0; m_stk = '0; m_ch = 0; m_cl = 0; m_rh = 0; m_rl = 0;
      for (int i = 0; i < 8; i++) m_t[i] = 0;
    end else begin
      logic [7:0] nl;
      logic [7:0] c;
      bit dh, dl;
      int a, b;
      m_stk = (m_stk & ~(clr_stb ? clr_mask : 8'h00)) | m_live;
      c = '0;
      c[2] = h_ovv; c[3] = l_ovv; c[4] = l_low & neg_diff;
      c[5] = neg_diff & ~l_low; c[6] = h_high; c[7] = txd_dom;
      nl = '0;
      for (int i = 2; i < 8; i++) begin
        if (!c[i]) m_t[i] = 0;
        else begin
          nl[i] = (m_t[i] == lim(i));
          if (us_tick && m_t[i] < lim(i)) m_t[i]++;
        end
      end
      dh = m_live[0] && h_edge && m_rh == 2;
      dl = m_live[1] && l_edge && m_rl == 2;
      nl[0] = dh ? 1'b0 : (m_cl > 3) ? 1'b1 : m_live[0];
      nl[1] = dl ? 1'b0 : (m_ch > 3) ? 1'b1 : m_live[1];
      m_rh = (!m_live[0] || dh) ? 0 : m_rh + int'(h_edge);
      m_rl = (!m_live[1] || dl) ? 0 : m_rl + int'(l_edge);
      if (dh || dl) begin m_ch = 0; m_cl = 0; end
      else begin
        a = m_ch + int'(h_edge); b = m_cl + int'(l_edge);
        if (a > 0 && b > 0) begin a--; b--; end
        m_ch = (a > 7) ? 7 : a; m_cl = (b > 7) ? 7 : b;
      end
      m_live = nl;
    end
  end

  // ---------------- check helpers ----------------
  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit h, bit l);
    h_edge = h; l_edge = l;
    @(negedge clk);
    h_edge = 0; l_edge = 0;
  endtask

  task automatic quiet_and_clear();
    {txd_dom, h_ovv, l_ovv, neg_diff, l_low, h_high} = '0;
    run(2);
    clr_stb = 1; clr_mask = 8'hFF;
    run(1);
    clr_stb = 0; clr_mask = 8'h00;
  endtask

  // per-cycle comparison against the model in the random phase
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk(fault_live == m_live, "R2 live flags", fault_live, m_live);
      chk(fault_sticky == m_stk, "R11 sticky", fault_sticky, m_stk);
      chk(wire_sel == exp_sel(m_live), "R10 wire_sel", wire_sel, exp_sel(m_live));
      chk(tx_en == !m_live[7], "R9 tx_en", tx_en, !m_live[7]);
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    run(3);
    rst_n = 1;
    run(1);
    // R1 reset state
    chk(fault_live == 0, "R1 live", fault_live, 0);
    chk(fault_sticky == 0, "R1 sticky", fault_sticky, 0);
    chk(wire_sel == 3'b001, "R1 wire_sel", wire_sel, 3'b001);
    chk(tx_en == 1, "R1 tx_en", tx_en, 1);

    us_tick = 1;

    // R2 balanced traffic sets nothing
    for (int i = 0; i < 12; i++) pulse(i % 2 == 0, i % 2 == 1);
    run(1);
    chk(fault_live[1:0] == 0, "R2 balanced", fault_live, 0);

    // R2 excess of 3 is not enough, 4 is
    for (int i = 0; i < 3; i++) pulse(0, 1);
    run(1);
    chk(fault_live[0] == 0, "R2 excess3", fault_live, 0);
    pulse(0, 1);
    run(1);
    chk(fault_live[0] == 1, "R2 excess4", fault_live, 1);
    chk(wire_sel == 3'b100, "R10 lonly", wire_sel, 3'b100);

    // R3 recovery on the third high-wire transition
    pulse(1, 0); pulse(1, 0);
    chk(fault_live[0] == 1, "R3 two edges hold", fault_live, 1);
    pulse(1, 0);
    chk(fault_live[0] == 0, "R3 third edge clears", fault_live, 0);
    // R3 counters restart from zero: 3 more low edges must not set
    for (int i = 0; i < 3; i++) pulse(0, 1);
    run(1);
    chk(fault_live[0] == 0, "R3 restart", fault_live, 0);
    pulse(0, 1); run(1);
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    // R2 mirror side: low wire missing
    for (int i = 0; i < 4; i++) pulse(1, 0);
    run(1);
    chk(fault_live[1] == 1, "R2 low missing", fault_live, 2);
    chk(wire_sel == 3'b010, "R10 honly", wire_sel, 3'b010);
    pulse(0, 1); pulse(0, 1); pulse(0, 1);
    chk(fault_live[1] == 0, "R3 low recovered", fault_live, 0);
    quiet_and_clear();

    // R4 battery short on the high wire: exact window
    h_ovv = 1;
    run(T_BATT);
    chk(fault_live[2] == 0, "R4 early", fault_live, 0);
    run(1);
    chk(fault_live[2] == 1, "R4 on time", fault_live, 4);
    // R8 interruption restarts
    h_ovv = 0; run(1);
    chk(fault_live[2] == 0, "R8 drop", fault_live, 0);
    h_ovv = 1; run(T_BATT - 1); h_ovv = 0; run(1); h_ovv = 1;
    run(T_BATT);
    chk(fault_live[2] == 0, "R8 restarted", fault_live, 0);
    run(1);
    chk(fault_live[2] == 1, "R8 requalified", fault_live, 4);
    h_ovv = 0;
    l_ovv = 1; run(T_BATT + 1);
    chk(fault_live[3] == 1, "R4 low batt", fault_live, 8);
    quiet_and_clear();

    // R6 wires shorted together
    neg_diff = 1;
    run(T_SHORT);
    chk(fault_live[5] == 0, "R6 early", fault_live, 0);
    run(1);
    chk(fault_live[5] == 1, "R6 set", fault_live, 32);
    // R5 ground short takes over when low flag joins
    l_low = 1;
    run(1);
    chk(fault_live[5] == 0, "R6 drops", fault_live, 0);
    run(T_SHORT);
    chk(fault_live[4] == 1, "R5 set", fault_live, 16);
    quiet_and_clear();

    // R7 + R10 priority: high wire fault wins over low wire fault
    h_high = 1; l_ovv = 1;
    run(T_HVDD);
    chk(fault_live[6] == 0, "R7 early", fault_live, 0);
    chk(wire_sel == 3'b010, "R10 low only", wire_sel, 3'b010);
    run(1);
    chk(fault_live[6] == 1, "R7 set", fault_live, 64);
    chk(wire_sel == 3'b100, "R10 priority", wire_sel, 3'b100);

    // R11 clear loses while live, clears by mask once released
    clr_stb = 1; clr_mask = 8'h40; run(1); clr_stb = 0;
    chk(fault_sticky[6] == 1, "R11 live wins", fault_sticky, 64);
    h_high = 0; run(2);
    clr_stb = 1; clr_mask = 8'h40; run(1); clr_stb = 0;
    chk(fault_sticky[6] == 0, "R11 masked clear", fault_sticky, 0);
    chk(fault_sticky[3] == 1, "R11 unmasked kept", fault_sticky, 8);
    quiet_and_clear();

    // R9 transmit watchdog
    txd_dom = 1;
    run(T_TX);
    chk(tx_en == 1, "R9 before limit", tx_en, 1);
    run(1);
    chk(tx_en == 0, "R9 cut off", tx_en, 0);
    chk(wire_sel == 3'b001, "R10 tx no wire", wire_sel, 3'b001);
    txd_dom = 0; run(1);
    chk(tx_en == 1, "R9 re-enabled", tx_en, 1);
    chk(fault_sticky[7] == 1, "R11 tx sticky", fault_sticky, 128);
    quiet_and_clear();

    // random phase compared every cycle with the model
    cmp_on = 1;
    for (int seg = 0; seg < 60; seg++) begin
      int mode;
      mode = $urandom_range(0, 2);
      for (int k = 0; k < 64; k++) begin
        us_tick = ($urandom_range(0, 1) == 1);
        if ($urandom_range(0, 29) == 0) txd_dom = ~txd_dom;
        if ($urandom_range(0, 39) == 0) h_ovv = ~h_ovv;
        if ($urandom_range(0, 39) == 0) l_ovv = ~l_ovv;
        if ($urandom_range(0, 39) == 0) neg_diff = ~neg_diff;
        if ($urandom_range(0, 39) == 0) l_low = ~l_low;
        if ($urandom_range(0, 49) == 0) h_high = ~h_high;
        h_edge = (mode != 2) && ($urandom_range(0, 2) == 0);
        l_edge = (mode != 1) && ($urandom_range(0, 2) == 0);
        clr_stb = ($urandom_range(0, 49) == 0);
        clr_mask = 8'($urandom_range(0, 255));
        @(negedge clk);
      end
    end
    cmp_on = 0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule